// File: doc/BRIEF.md
# Inter-Packet Gap Covert Channel Modem

This block hides a slow side-channel bit stream in the number of idle characters that separate frames. The frames themselves stay ordinary. The transmit half generates a character stream: a frame-start, a fixed number of data characters, a frame-end, and then an idle run. At each frame-end it may take one secret bit through a ready/valid handshake. A taken '1' lengthens the idle run to the base count plus a programmable delta. A taken '0' shortens it to the base count minus the delta. When no bit is offered, the run keeps the plain base length.

The receive half watches an incoming character stream. It counts the idle characters that follow a frame-end, and at the next frame-start it slices the count against the base. It emits a one-cycle bit-valid pulse together with the recovered bit.

The receiver does not trust a gap whose start it never saw, so a gap measured after reset or after link loss is dropped. It also drops a gap that lies so close to the base that it most likely carried no bit. The idle counters saturate at their top value instead of wrapping. The defaults are a base of 3562 idles and a delta of 128 idles. Payload content, the physical layer and error correction belong to neighbouring blocks.

Top module: `ipg_covert_modem`

## Requirements
- R1: Character codes are 2 bits: idle = 0, frame-start = 1, data = 2, frame-end = 3. After reset `txChar` repeats this sequence: one frame-start, FRAME_LEN-2 data characters, one frame-end, then an idle run.
- R2: When a '1' is accepted at a frame-end, the idle run that follows is exactly BASE_GAP+DELTA characters long.
- R3: When a '0' is accepted at a frame-end, the idle run that follows is exactly BASE_GAP-DELTA characters long.
- R4: When no bit is offered at a frame-end, the idle run that follows is exactly BASE_GAP characters long.
- R5: `txBitReady` is high in exactly the cycles in which `txChar` is frame-end. A bit is taken on a clock edge where both `txBitReady` and `txBitValid` are high.
- R6: A frame-start on `rxChar` that follows a frame-end with the link up produces a one-cycle `rxBitValid` pulse on the next cycle. The pulse appears when the idle count differs from BASE_GAP by at least DELTA/4. `rxBit` is 1 when the count is greater than or equal to BASE_GAP, and 0 otherwise.
- R7: A gap whose idle count lies strictly within DELTA/4 of BASE_GAP produces no `rxBitValid` pulse.
- R8: Idles that reach a frame-start without a preceding frame-end since reset produce no `rxBitValid` pulse.
- R9: If `rxLinkUp` drops at any time during a gap, that gap produces no pulse. The next complete gap is decoded normally.
- R10: The receive idle counter saturates at 2^CNT_W-1. A gap longer than that decodes as '1'.
- R11: During reset and on the first cycle after it, `rxBitValid` is 0 and `txChar` is frame-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txBitValid | input | 1 | Secret bit offered |
| txBit | input | 1 | Secret bit value |
| txBitReady | output | 1 | Transmitter takes a bit this cycle |
| txChar | output | 2 | Outgoing character code |
| rxChar | input | 2 | Incoming character code |
| rxLinkUp | input | 1 | Receive link is valid |
| rxBitValid | output | 1 | Recovered bit pulse |
| rxBit | output | 1 | Recovered bit value |

## Verification
The assertions take for granted that the parameters give a gap of at least one idle, a frame of at least three characters, and BASE_GAP+DELTA within the counter range. The stimulus holds to these by building the modem with small values (base 40, delta 8, 8-bit counters). The receive properties also assume that the incoming stream uses only the four legal codes. The bench writes `rxChar` one character per clock, shortly after each rising edge, so every frame-start it sends is held for one full cycle. A secret bit is held valid until a frame-end accepts it, and it is released only after the accepting edge, so no offer is withdrawn while ready is high.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_START = 2'd1,
    CH_DATA  = 2'd2,
    CH_TERM  = 2'd3
  } char_t;

  typedef enum logic [1:0] {
    TX_START,
    TX_BODY,
    TX_TERM,
    TX_GAP
  } txState_t;

  typedef struct packed {
    logic txLoadBody;
    logic txLoadGap;
    logic txDec;
    logic rxClr;
    logic rxInc;
    logic rxDecide;
  } strobes_t;
endpackage

// File: rtl/ipg_ctrl.sv
module ipg_ctrl
  import ipg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       txLast,
  input  logic [1:0] rxChar,
  input  logic       rxLinkUp,
  output logic [1:0] txChar,
  output logic       txBitReady,
  output strobes_t   stb
);
  txState_t txState, txNext;
  logic     rxInGap;

  always_comb begin
    txNext = txState;
    case (txState)
      TX_START: txNext = TX_BODY;
      TX_BODY:  if (txLast) txNext = TX_TERM;
      TX_TERM:  txNext = TX_GAP;
      TX_GAP:   if (txLast) txNext = TX_START;
      default:  txNext = TX_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) txState <= TX_START;
    else     txState <= txNext;
  end

  always_comb begin
    case (txState)
      TX_START: txChar = CH_START;
      TX_BODY:  txChar = CH_DATA;
      TX_TERM:  txChar = CH_TERM;
      default:  txChar = CH_IDLE;
    endcase
  end

  assign txBitReady = (txState == TX_TERM);

  // A gap counts only when its frame-end was seen on a live link.
  always_ff @(posedge clk) begin
    if (rst || !rxLinkUp)            rxInGap <= 1'b0;
    else if (rxChar == CH_TERM)      rxInGap <= 1'b1;
    else if (rxChar == CH_START)     rxInGap <= 1'b0;
  end

  always_comb begin
    stb.txLoadBody = (txState == TX_START);
    stb.txLoadGap  = (txState == TX_TERM);
    stb.txDec      = (txState == TX_BODY) || (txState == TX_GAP);
    stb.rxClr      = (rxChar == CH_TERM);
    stb.rxInc      = rxInGap && (rxChar == CH_IDLE);
    stb.rxDecide   = rxInGap && rxLinkUp && (rxChar == CH_START);
  end
endmodule

// File: rtl/ipg_dp.sv
module ipg_dp
  import ipg_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BASE_GAP  = 3562,
  parameter int DELTA     = 128,
  parameter int FRAME_LEN = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  strobes_t stb,
  input  logic     txBitValid,
  input  logic     txBit,
  output logic     txLast,
  output logic     rxBitValid,
  output logic     rxBit
);
  localparam int QUARTER = DELTA / 4;
  localparam logic [CNT_W-1:0] GAP_ONE  = CNT_W'(BASE_GAP + DELTA);
  localparam logic [CNT_W-1:0] GAP_ZERO = CNT_W'(BASE_GAP - DELTA);
  localparam logic [CNT_W-1:0] GAP_NONE = CNT_W'(BASE_GAP);
  localparam logic [CNT_W-1:0] BODY_LEN = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] LOW_EDGE = CNT_W'(BASE_GAP - QUARTER);
  localparam logic [CNT_W-1:0] HIGH_EDGE = CNT_W'(BASE_GAP + QUARTER);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] gapSel;
  logic [CNT_W-1:0] idleCnt;
  logic             deadZone;
  logic             sliceOk;

  always_comb begin
    if (txBitValid) gapSel = txBit ? GAP_ONE : GAP_ZERO;
    else            gapSel = GAP_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                 txCnt <= '0;
    else if (stb.txLoadBody) txCnt <= BODY_LEN;
    else if (stb.txLoadGap)  txCnt <= gapSel;
    else if (stb.txDec)      txCnt <= txCnt - 1'b1;
  end

  assign txLast = (txCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || stb.rxClr)                     idleCnt <= '0;
    else if (stb.rxInc && idleCnt != CNT_MAX) idleCnt <= idleCnt + 1'b1;
  end

  assign deadZone = (idleCnt > LOW_EDGE) && (idleCnt < HIGH_EDGE);
  assign sliceOk  = stb.rxDecide && !deadZone;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxBitValid <= 1'b0;
      rxBit      <= 1'b0;
    end else begin
      rxBitValid <= sliceOk;
      if (sliceOk) rxBit <= (idleCnt >= GAP_NONE);
    end
  end
endmodule

// File: rtl/ipg_covert_modem.sv
module ipg_covert_modem
  import ipg_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BASE_GAP  = 3562,
  parameter int DELTA     = 128,
  parameter int FRAME_LEN = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txBitValid,
  input  logic       txBit,
  output logic       txBitReady,
  output logic [1:0] txChar,
  input  logic [1:0] rxChar,
  input  logic       rxLinkUp,
  output logic       rxBitValid,
  output logic       rxBit
);
  strobes_t stb;
  logic     txLast;

  ipg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .txLast(txLast), .rxChar(rxChar),
    .rxLinkUp(rxLinkUp), .txChar(txChar), .txBitReady(txBitReady), .stb(stb)
  );

  ipg_dp #(
    .CNT_W(CNT_W), .BASE_GAP(BASE_GAP), .DELTA(DELTA), .FRAME_LEN(FRAME_LEN)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .txBitValid(txBitValid), .txBit(txBit),
    .txLast(txLast), .rxBitValid(rxBitValid), .rxBit(rxBit)
  );
endmodule

// File: rtl/ipg_covert_modem_chk.sv
module ipg_covert_modem_chk (
  input logic       clk,
  input logic       rst,
  input logic       txBitReady,
  input logic [1:0] txChar,
  input logic [1:0] rxChar,
  input logic       rxLinkUp,
  input logic       rxBitValid
);
  // R1
  start_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    txChar == 2'd1 |=> txChar == 2'd2);

  // R1
  idle_then_idle_or_start_chk: assert property (@(posedge clk) disable iff (rst)
    txChar == 2'd0 |=> (txChar == 2'd0 || txChar == 2'd1));

  // R5
  ready_then_gap_chk: assert property (@(posedge clk) disable iff (rst)
    txBitReady |=> txChar == 2'd0);

  // R6
  pulse_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    rxBitValid |-> ($past(rxChar) == 2'd1 && $past(rxLinkUp)));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rxBitValid |=> !rxBitValid);

  // R9
  no_pulse_on_link_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !rxLinkUp |=> !rxBitValid);
endmodule

bind ipg_covert_modem ipg_covert_modem_chk u_chk (
  .clk(clk), .rst(rst), .txBitReady(txBitReady), .txChar(txChar),
  .rxChar(rxChar), .rxLinkUp(rxLinkUp), .rxBitValid(rxBitValid)
);

// File: tb/ipg_covert_modem_tb.sv
module ipg_covert_modem_tb;
  localparam int CLK_P = 10;
  localparam int BASE  = 40;
  localparam int DLT   = 8;
  localparam int FLEN  = 6;
  localparam int CW    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txBitValid = 1'b0;
  logic       txBit = 1'b0;
  logic       txBitReady;
  logic [1:0] txChar;
  logic [1:0] rxChar = 2'd0;
  logic       rxLinkUp = 1'b1;
  logic       rxBitValid;
  logic       rxBit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int txQ[$];
  logic [1:0] rxQ[$];

  always #(CLK_P/2) clk = ~clk;

  ipg_covert_modem #(.CNT_W(CW), .BASE_GAP(BASE), .DELTA(DLT), .FRAME_LEN(FLEN)) u_dut (
    .clk(clk), .rst(rst), .txBitValid(txBitValid), .txBit(txBit),
    .txBitReady(txBitReady), .txChar(txChar), .rxChar(rxChar),
    .rxLinkUp(rxLinkUp), .rxBitValid(rxBitValid), .rxBit(rxBit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // TX monitor: frame shape, handshake, idle run lengths
  logic [1:0] txPrev = 2'd0;
  int bodyCnt = 0;
  int gapCnt = 0;
  bit txSeenTerm = 0;
  always @(negedge clk) begin
    if (!rst) begin
      check(txBitReady == (txChar == 2'd3), "R5 ready vs frame-end", txBitReady, txChar == 2'd3);
      if (txChar == 2'd2) bodyCnt++;
      if (txChar == 2'd0) gapCnt++;
      if (txChar == 2'd3) begin
        check(bodyCnt == FLEN - 2, "R1 data run", bodyCnt, FLEN - 2);
        bodyCnt = 0;
        gapCnt = 0;
        txSeenTerm = 1;
        if (txBitValid) txQ.push_back(txBit ? BASE + DLT : BASE - DLT);
        else txQ.push_back(BASE);
      end
      if (txChar == 2'd1) begin
        bodyCnt = 0;
        if (txSeenTerm) begin
          if (txQ.size() == 0) check(0, "R2/R3/R4 queue empty", gapCnt, -1);
          else begin
            int e;
            e = txQ.pop_front();
            if (e == BASE + DLT)      check(gapCnt == e, "R2 gap after one", gapCnt, e);
            else if (e == BASE - DLT) check(gapCnt == e, "R3 gap after zero", gapCnt, e);
            else                      check(gapCnt == e, "R4 unmodulated gap", gapCnt, e);
          end
        end
        gapCnt = 0;
      end
      txPrev = txChar;
    end
  end

  // RX monitor: one expectation per frame-start sent
  bit rxSawStart = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rxSawStart) begin
        logic [1:0] e;
        if (rxQ.size() == 0) begin
          e = 2'b00;
          check(0, "R6 rx queue empty", 0, 0);
        end else e = rxQ.pop_front();
        check(rxBitValid == e[1], "R6/R7/R8/R9/R10 pulse", rxBitValid, e[1]);
        if (e[1]) check(rxBit == e[0], "R6/R10 bit value", rxBit, e[0]);
      end else if (rxBitValid) begin
        check(0, "R6 unexpected pulse", 1, 0);
      end
      rxSawStart = (rxChar == 2'd1);
    end
  end

  task automatic sendBit(input bit b);
    @(posedge clk); #1;
    txBitValid = 1'b1;
    txBit = b;
    do @(negedge clk); while (txChar != 2'd3);
    @(posedge clk); #1;
    txBitValid = 1'b0;
  endtask

  task automatic rxSend(input logic [1:0] c);
    @(posedge clk); #1;
    rxChar = c;
  endtask

  // gap of n idles; dropLink pulls the link down for one cycle mid-gap
  task automatic sendGap(input int n, input bit dropLink, input bit expV, input bit expB);
    rxSend(2'd3);
    for (int i = 0; i < n; i++) begin
      rxSend(2'd0);
      rxLinkUp = !(dropLink && i == n / 2);
    end
    rxSend(2'd1);
    rxLinkUp = 1'b1;
    rxQ.push_back({expV, expB});
    rxSend(2'd2);
    rxSend(2'd2);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: values held in reset
    check(rxBitValid == 1'b0, "R11 rxBitValid in reset", rxBitValid, 0);
    check(txChar == 2'd1, "R11 txChar in reset", txChar, 1);
    rst = 1'b0;
    @(negedge clk);
    check(txChar == 2'd1, "R11 first char after reset", txChar, 1);
    check(rxBitValid == 1'b0, "R11 rxBitValid after reset", rxBitValid, 0);

    // R2 / R3 / R5: modulated gaps, then R4 with nothing offered
    sendBit(1'b1);
    sendBit(1'b0);
    sendBit(1'b1);
    sendBit(1'b1);
    sendBit(1'b0);
    repeat (3 * (BASE + DLT + FLEN)) @(posedge clk);

    // R8: idles then start with no frame-end since reset
    for (int i = 0; i < 50; i++) rxSend(2'd0);
    rxSend(2'd1);
    rxQ.push_back(2'b00);
    rxSend(2'd2);

    sendGap(48, 0, 1, 1);              // R6 long gap -> 1
    sendGap(32, 0, 1, 0);              // R6 short gap -> 0
    sendGap(40, 0, 0, 0);              // R7 exactly base
    sendGap(41, 0, 0, 0);              // R7 inside dead zone
    sendGap(39, 0, 0, 0);              // R7 inside dead zone
    sendGap(42, 0, 1, 1);              // R6 upper edge -> 1
    sendGap(38, 0, 1, 0);              // R6 lower edge -> 0
    sendGap(48, 1, 0, 0);              // R9 link lost mid gap
    sendGap(48, 0, 1, 1);              // R9 next gap decodes
    sendGap(260, 0, 1, 1);             // R10 saturated count -> 1
    sendGap(33, 0, 1, 0);              // R10 counter clears after saturation
    repeat (4) @(posedge clk);

    check(rxQ.size() == 0, "R6 all rx expectations consumed", rxQ.size(), 0);
    finish_run();
  end
endmodule